// File: doc/BRIEF.md
# Peripheral ROM Window Selector

This block sits on a 16-bit address bus and decides, for each access that falls in the peripheral ROM region from $C100 to $CFFF, which memory answers. There are three possible answers: the internal system ROM, the 256-byte ROM of the card in the addressed slot, or the 2 KB expansion ROM shared by all slots and claimed by whichever slot was touched last. Addresses outside that region get no source at all.

An owner register records which slot currently holds the expansion window. A valid access to a slot page claims the window for that slot. A valid access to $CFFF releases it, so the owner returns to 0. Two mode inputs shape the decode. An override input sends the whole region to internal ROM and freezes the owner. A slot-3 enable input, when low, replaces slot 3's card ROM and its expansion ROM with internal ROM. There is no read/write input, because both directions decode the same way and update the owner by the same rules.

The source select and slot index are combinational functions of the current address, the mode inputs and the owner register. The owner register changes on the clock edge that ends a valid bus cycle.

Top module: `pwin_sel`

## Requirements
- R1: While `int_rom_ovr` is 1, every address from $C100 to $CFFF gives `src_sel` = 1 (internal) and `slot_idx` = 0, and valid cycles leave the owner unchanged.
- R2: Addresses outside $C100–$CFFF give `src_sel` = 0 (none) and `slot_idx` = 0, and do not change the owner.
- R3: With the override off, an address from $C100 to $C7FF whose slot number in bits 10:8 is not 3 gives `src_sel` = 2 (card) and `slot_idx` equal to bits 10:8.
- R4: With the override off, a valid access from $C100 to $C7FF makes bits 10:8 the new owner on the next clock edge. This holds for slot 3 as well, whatever `slot3_en` is.
- R5: A slot-page access to slot 3 ($C300–$C3FF) gives internal (1) with `slot_idx` 0 when `slot3_en` is 0, and card (2) with `slot_idx` 3 when `slot3_en` is 1.
- R6: With the override off, an address from $C800 to $CFFE with a nonzero owner gives `src_sel` = 3 (expansion) and `slot_idx` = owner. The exception is owner 3 with `slot3_en` low.
- R7: In the expansion window, owner 3 with `slot3_en` = 0 gives internal (1) with `slot_idx` 0.
- R8: An access to $CFFF is decoded as if the owner were 0. A valid access there with the override off clears the owner on the next edge.
- R9: In the expansion window, owner 0 gives `src_sel` = 0 (none) and `slot_idx` = 0.
- R10: Reset sets the owner to 0.
- R11: When `bus_valid` is 0, the owner does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Address is a live bus cycle this clock |
| addr | input | 16 | Bus address |
| int_rom_ovr | input | 1 | Route the whole peripheral region to internal ROM |
| slot3_en | input | 1 | 1 lets slot 3 use its card ROMs, 0 routes them to internal |
| src_sel | output | 2 | 0 none, 1 internal, 2 card page, 3 expansion |
| slot_idx | output | 3 | Slot served when `src_sel` is 2 or 3, else 0 |

## Verification
The assertions assume that `addr` and the mode inputs are stable for the whole clock period in which they are sampled, and that only valid cycles count for ownership. The stimulus changes inputs only on the falling edge and holds them through the next rising edge. The random mix favours the slot pages and the expansion window, and it hits $CFFF often enough that the owner keeps cycling through claim and release with the mode inputs in every combination.

// File: rtl/pwin_sel.sv
module pwin_sel #(
  parameter logic [15:0] CLR_ADDR = 16'hCFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic [15:0] addr,
  input  logic        int_rom_ovr,
  input  logic        slot3_en,
  output logic [1:0]  src_sel,
  output logic [2:0]  slot_idx
);
  localparam logic [1:0] SRC_NONE = 2'd0;
  localparam logic [1:0] SRC_INT  = 2'd1;
  localparam logic [1:0] SRC_CARD = 2'd2;
  localparam logic [1:0] SRC_EXP  = 2'd3;

  logic [2:0] owner_q;

  wire       in_c      = addr[15:12] == 4'hC;
  wire       slot_area = in_c && !addr[11] && (addr[10:8] != 3'd0);
  wire       exp_area  = in_c && addr[11];
  wire       clr_hit   = addr == CLR_ADDR;
  wire [2:0] eff_owner = clr_hit ? 3'd0 : owner_q;
  wire [2:0] pick      = slot_area ? addr[10:8] : eff_owner;

  always_comb begin
    src_sel  = SRC_NONE;
    slot_idx = 3'd0;
    if (slot_area || exp_area) begin
      if (int_rom_ovr)
        src_sel = SRC_INT;
      else if (pick == 3'd3 && !slot3_en)
        src_sel = SRC_INT;
      else if (pick != 3'd0) begin
        src_sel  = slot_area ? SRC_CARD : SRC_EXP;
        slot_idx = pick;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      owner_q <= 3'd0;
    else if (bus_valid && !int_rom_ovr) begin
      if (slot_area)
        owner_q <= addr[10:8];
      else if (clr_hit)
        owner_q <= 3'd0;
    end
  end
endmodule

// File: rtl/pwin_sel_chk.sv
module pwin_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic [15:0] addr,
  input logic        int_rom_ovr,
  input logic        slot3_en,
  input logic [1:0]  src_sel,
  input logic [2:0]  slot_idx,
  input logic [2:0]  owner_q
);
  wire in_win   = addr >= 16'hC100 && addr <= 16'hCFFF;
  wire in_slots = addr >= 16'hC100 && addr <= 16'hC7FF;
  wire in_exp   = addr >= 16'hC800 && addr <= 16'hCFFE;

  assert_override_int_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rom_ovr && in_win) |-> (src_sel == 2'd1 && slot_idx == 3'd0));

  assert_override_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int_rom_ovr |=> $stable(owner_q));

  assert_outside_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (src_sel == 2'd0 && slot_idx == 3'd0));

  assert_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !int_rom_ovr && in_slots) |=> (owner_q == $past(addr[10:8])));

  assert_exp_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_rom_ovr && in_exp && owner_q != 3'd0 && !(owner_q == 3'd3 && !slot3_en))
      |-> (src_sel == 2'd3 && slot_idx == owner_q));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !int_rom_ovr && addr == 16'hCFFF) |=> (owner_q == 3'd0));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> $stable(owner_q));
endmodule

bind pwin_sel pwin_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .addr(addr),
  .int_rom_ovr(int_rom_ovr), .slot3_en(slot3_en),
  .src_sel(src_sel), .slot_idx(slot_idx), .owner_q(owner_q)
);

// File: tb/pwin_sel_test.sv
module pwin_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        int_rom_ovr = 1'b0;
  logic        slot3_en = 1'b1;
  logic [1:0]  src_sel;
  logic [2:0]  slot_idx;

  int checks = 0;
  int fails = 0;
  logic [2:0] m_owner = 3'd0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwin_sel uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .addr(addr),
    .int_rom_ovr(int_rom_ovr), .slot3_en(slot3_en),
    .src_sel(src_sel), .slot_idx(slot_idx)
  );

  function automatic void expect_of(input logic [15:0] a, input logic ovr, input logic en,
                                    input logic [2:0] own, output logic [1:0] s,
                                    output logic [2:0] i, output string tag);
    logic [2:0] p;
    s = 2'd0; i = 3'd0;
    if (a < 16'hC100 || a > 16'hCFFF) begin tag = "R2"; return; end
    if (ovr) begin s = 2'd1; tag = "R1"; return; end
    if (a <= 16'hC7FF) begin
      p = a[10:8];
      if (p == 3'd3 && !en) begin s = 2'd1; tag = "R5"; end
      else begin s = 2'd2; i = p; tag = (p == 3'd3) ? "R5" : "R3"; end
      return;
    end
    p = (a == 16'hCFFF) ? 3'd0 : own;
    if (a == 16'hCFFF) tag = "R8";
    else if (p == 3'd0) tag = "R9";
    else if (p == 3'd3 && !en) tag = "R7";
    else tag = "R6";
    if (p == 3'd0) return;
    if (p == 3'd3 && !en) begin s = 2'd1; return; end
    s = 2'd3; i = p;
  endfunction

  task automatic step(input logic v, input logic [15:0] a, input logic ovr, input logic en,
                      input string note);
    logic [1:0] es; logic [2:0] ei; string tag;
    @(negedge clk);
    bus_valid = v; addr = a; int_rom_ovr = ovr; slot3_en = en;
    #1;
    expect_of(a, ovr, en, m_owner, es, ei, tag);
    checks++;
    if (src_sel !== es || slot_idx !== ei) begin
      fails++;
      $display("FAIL %s %s addr=%h owner=%0d: got src=%0d idx=%0d, expected src=%0d idx=%0d",
               tag, note, a, m_owner, src_sel, slot_idx, es, ei);
    end
    @(posedge clk);
    if (v && !ovr) begin
      if (a >= 16'hC100 && a <= 16'hC7FF) m_owner = a[10:8];
      else if (a == 16'hCFFF) m_owner = 3'd0;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(1'b0, 16'hC900, 1'b0, 1'b1, "R10 owner zero after reset");
    step(1'b1, 16'hC0FF, 1'b0, 1'b1, "R2 io page");
    step(1'b1, 16'hD000, 1'b0, 1'b1, "R2 above window");
    step(1'b1, 16'hC512, 1'b0, 1'b1, "R3 R4 claim slot 5");
    step(1'b1, 16'hC800, 1'b0, 1'b1, "R6 slot 5 owns");
    step(1'b0, 16'hC200, 1'b0, 1'b1, "R11 idle slot 2");
    step(1'b1, 16'hCA00, 1'b0, 1'b1, "R11 owner still 5");
    step(1'b1, 16'hC100, 1'b1, 1'b1, "R1 override slot page");
    step(1'b1, 16'hCFFF, 1'b1, 1'b1, "R1 override release");
    step(1'b1, 16'hCFFE, 1'b0, 1'b1, "R1 owner frozen");
    step(1'b1, 16'hC3FF, 1'b0, 1'b0, "R5 slot3 internal, R4 claim 3");
    step(1'b1, 16'hCC00, 1'b0, 1'b0, "R7 owner 3 internal");
    step(1'b1, 16'hCC00, 1'b0, 1'b1, "R6 owner 3 enabled");
    step(1'b1, 16'hC300, 1'b0, 1'b1, "R5 slot3 card");
    step(1'b1, 16'hCFFF, 1'b0, 1'b1, "R8 release");
    step(1'b1, 16'hC800, 1'b0, 1'b1, "R9 no owner");
    step(1'b1, 16'hC7FF, 1'b0, 1'b1, "R3 slot 7 top");
    step(1'b1, 16'hCFFF, 1'b0, 1'b1, "R8 decode as none");
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a; int r;
      r = $urandom_range(0, 99);
      if (r < 40) a = 16'hC100 + 16'($urandom_range(0, 16'h06FF));
      else if (r < 80) a = 16'hC800 + 16'($urandom_range(0, 16'h07FF));
      else if (r < 90) a = 16'hCFFF;
      else a = 16'($urandom());
      step(1'($urandom_range(0, 9) != 0), a, 1'($urandom_range(0, 7) == 0),
           1'($urandom_range(0, 1)), "random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule